// File: doc/BRIEF.md
# Miss Tracker with Deferred Snoop Invalidation

This block holds the single outstanding miss of a private data cache. A CPU access that missed is accepted on a ready/valid input. The block then issues one coherent bus request for the whole line. A read miss becomes a shared-read request, and a write to a line that is held readable but not writable becomes an upgrade request that carries no payload. The entry stays busy until the fill response arrives. While it is busy, further misses are held off.

Invalidating snoops that hit the pending line before the fill cannot act on it, because the line is not valid yet. The block records such a snoop in a deferred flag instead. When the fill comes, the line is installed and the recorded invalidation is applied in the same step, so the line ends up Invalid. The CPU still receives the fill data, in a response that is tagged as carrying an invalidation. The CPU response leaves one cycle after the fill is handled. It carries the 8-byte word that the original access addressed.

Top module: `miss_tracker`

## Requirements
- R1: After reset, miss_ready_o is 1, bus_req_valid_o and cpu_rsp_valid_o are 0, and line_state_o is 0 (Invalid). Line state encoding: 0 Invalid, 1 Shared, 2 Modified.
- R2: An accepted read miss (miss_write_i=0) produces a one-cycle bus_req_valid_o pulse in the cycle after the accepting edge. The pulse carries bus_req_cmd_o=1 (shared read), bus_req_addr_o equal to the miss address with its low 6 bits cleared, and bus_req_size_o=64.
- R3: An accepted write miss (miss_write_i=1, line held Shared) produces bus_req_cmd_o=2 (upgrade) with bus_req_size_o=0 and the line-aligned address. line_state_o reads 1 while the upgrade is pending, and 0 while a read miss is pending.
- R4: While an entry is pending, miss_ready_o is 0 and no further bus request is issued. A miss held valid across the busy period is accepted on the edge after the fill edge.
- R5: An invalidating snoop (snp_inv_i=1) to the pending line before the fill leaves line_state_o unchanged.
- R6: A fill for a read miss with no recorded snoop leaves line_state_o at 1. The response carries cpu_rsp_inval_o=0, cpu_rsp_addr_o equal to the miss address with its low 3 bits cleared, and cpu_rsp_data_o equal to 64-bit word number addr[5:3] of fill_data_i (word k at bits k*64 and up).
- R7: If an invalidating snoop to the pending line arrived before the fill, or arrives in the same cycle as the fill, the fill leaves line_state_o at 0. The response then carries cpu_rsp_inval_o=1 and still delivers the fill word.
- R8: A fill for an upgrade leaves line_state_o at 2, or at 0 if an invalidation was recorded, and returns cpu_rsp_data_o=0.
- R9: cpu_rsp_valid_o is a one-cycle pulse, raised in the cycle after the edge following the fill edge.
- R10: Snoops to another line, non-invalidating snoops (snp_inv_i=0) and snoops while idle have no effect on line_state_o or on the response tag.
- R11: The deferred flag is cleared when the entry retires. A later miss to the same line without a snoop completes with cpu_rsp_inval_o=0.
- R12: A fill while no entry is pending produces no response and leaves line_state_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | CPU miss request valid |
| miss_ready_o | output | 1 | Entry free; miss accepted when both high |
| miss_write_i | input | 1 | 1: write to a Shared line, 0: read |
| miss_addr_i | input | ADDR_W | Byte address of the miss |
| bus_req_valid_o | output | 1 | Bus request pulse |
| bus_req_cmd_o | output | 2 | 1 shared read, 2 upgrade |
| bus_req_addr_o | output | ADDR_W | Line-aligned request address |
| bus_req_size_o | output | 7 | Payload bytes requested (64 or 0) |
| snp_valid_i | input | 1 | Snoop valid |
| snp_inv_i | input | 1 | Snoop invalidates the line |
| snp_addr_i | input | ADDR_W | Snoop address |
| fill_valid_i | input | 1 | Fill response valid |
| fill_data_i | input | 512 | Fill line data |
| cpu_rsp_valid_o | output | 1 | CPU response pulse |
| cpu_rsp_inval_o | output | 1 | Response followed by invalidation |
| cpu_rsp_addr_o | output | ADDR_W | Word-aligned original address |
| cpu_rsp_data_o | output | 64 | Requested word (0 for upgrade) |
| line_state_o | output | 2 | State of the tracked line |

## Verification
The bus request is due in the cycle after the accepting edge. The line state after a fill is due right after the fill edge, and the CPU response exactly one edge later. The driver drives on falling edges. When it drives a fill, it pushes the expected response together with the cycle number in which it must appear. The monitor compares each response against the head of that queue, flags any response that arrives early or without an expected entry, and flags any expected entry whose due cycle passes with no response. Bus request and line state are checked on the falling edge right after the edge that is meant to update them.

// File: rtl/miss_tracker_pkg.sv
package miss_tracker_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE      = 2'd0,
    BUS_RD_SHARED = 2'd1,
    BUS_UPGRADE   = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;
endpackage

// File: rtl/mt_req_build.sv
module mt_req_build import miss_tracker_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    accept_i,
  input  logic                    write_i,
  input  logic [ADDR_W-OFF_W-1:0] tag_i,
  output logic                    req_valid_o,
  output logic [1:0]              req_cmd_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [OFF_W:0]          req_size_o
);
  localparam logic [OFF_W:0] LINE_SIZE = (OFF_W+1)'(1 << OFF_W);

  bus_cmd_e cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      cmd_q       <= BUS_IDLE;
      req_addr_o  <= '0;
      req_size_o  <= '0;
    end else begin
      req_valid_o <= accept_i;
      if (accept_i) begin
        // read miss fetches whole line shared; write to Shared line only upgrades
        cmd_q      <= write_i ? BUS_UPGRADE : BUS_RD_SHARED;
        req_addr_o <= {tag_i, {OFF_W{1'b0}}};
        req_size_o <= write_i ? '0 : LINE_SIZE;
      end
    end
  end

  assign req_cmd_o = cmd_q;
endmodule

// File: rtl/mt_snoop_latch.sv
module mt_snoop_latch #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ent_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] ent_tag_i,
  input  logic                    snp_valid_i,
  input  logic                    snp_inv_i,
  input  logic [ADDR_W-1:0]       snp_addr_i,
  input  logic                    retire_i,
  output logic                    hit_o,
  output logic                    deferred_o
);
  logic unused_snp_lo;
  assign unused_snp_lo = ^snp_addr_i[OFF_W-1:0];

  assign hit_o = ent_valid_i & snp_valid_i & snp_inv_i &
                 (snp_addr_i[ADDR_W-1:OFF_W] == ent_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       deferred_o <= 1'b0;
    else if (retire_i) deferred_o <= 1'b0;  // a same-cycle hit is consumed by the retiring fill
    else if (hit_o)    deferred_o <= 1'b1;
  end
endmodule

// File: rtl/mt_fill_path.sv
module mt_fill_path #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   fire_i,
  input  logic [LINE_BYTES*8-1:0]                line_i,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0] widx_i,
  input  logic                                   write_i,
  input  logic                                   inval_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  output logic                                   rsp_valid_o,
  output logic                                   rsp_inval_o,
  output logic [ADDR_W-1:0]                      rsp_addr_o,
  output logic [WORD_BYTES*8-1:0]                rsp_data_o
);
  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int WORD_W = WORD_BYTES * 8;

  logic [WORD_W-1:0] words [WORDS];
  logic              pend_q;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign words[k] = line_i[k*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_inval_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_data_o  <= '0;
    end else begin
      pend_q      <= fire_i;
      rsp_valid_o <= pend_q;   // one cycle after the fill is handled
      if (fire_i) begin
        rsp_inval_o <= inval_i;
        rsp_addr_o  <= addr_i;
        rsp_data_o  <= write_i ? '0 : words[widx_i];
      end
    end
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker import miss_tracker_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      miss_valid_i,
  output logic                      miss_ready_o,
  input  logic                      miss_write_i,
  input  logic [ADDR_W-1:0]         miss_addr_i,
  output logic                      bus_req_valid_o,
  output logic [1:0]                bus_req_cmd_o,
  output logic [ADDR_W-1:0]         bus_req_addr_o,
  output logic [$clog2(LINE_BYTES):0] bus_req_size_o,
  input  logic                      snp_valid_i,
  input  logic                      snp_inv_i,
  input  logic [ADDR_W-1:0]         snp_addr_i,
  input  logic                      fill_valid_i,
  input  logic [LINE_BYTES*8-1:0]   fill_data_i,
  output logic                      cpu_rsp_valid_o,
  output logic                      cpu_rsp_inval_o,
  output logic [ADDR_W-1:0]         cpu_rsp_addr_o,
  output logic [WORD_BYTES*8-1:0]   cpu_rsp_data_o,
  output logic [1:0]                line_state_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);

  logic              ent_valid_q, ent_write_q;
  logic [ADDR_W-1:0] ent_addr_q;
  line_st_e          ln_st_q;
  logic              accept, fill_fire, snp_hit, deferred, inval_now;
  logic              unused_miss_lo;

  assign unused_miss_lo = ^miss_addr_i[WOFF_W-1:0];
  assign miss_ready_o   = ~ent_valid_q;
  assign accept         = miss_valid_i & miss_ready_o;
  assign fill_fire      = fill_valid_i & ent_valid_q;
  assign inval_now      = deferred | snp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid_q <= 1'b0;
      ent_write_q <= 1'b0;
      ent_addr_q  <= '0;
      ln_st_q     <= LN_INV;
    end else if (accept) begin
      ent_valid_q <= 1'b1;
      ent_write_q <= miss_write_i;
      ent_addr_q  <= {miss_addr_i[ADDR_W-1:WOFF_W], {WOFF_W{1'b0}}};
      ln_st_q     <= miss_write_i ? LN_SHR : LN_INV;
    end else if (fill_fire) begin
      ent_valid_q <= 1'b0;
      // install, then apply recorded invalidation in the same step
      ln_st_q     <= inval_now ? LN_INV : (ent_write_q ? LN_MOD : LN_SHR);
    end
  end

  assign line_state_o = ln_st_q;

  mt_req_build #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .write_i     (miss_write_i),
    .tag_i       (miss_addr_i[ADDR_W-1:OFF_W]),
    .req_valid_o (bus_req_valid_o),
    .req_cmd_o   (bus_req_cmd_o),
    .req_addr_o  (bus_req_addr_o),
    .req_size_o  (bus_req_size_o)
  );

  mt_snoop_latch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_snp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ent_valid_i (ent_valid_q),
    .ent_tag_i   (ent_addr_q[ADDR_W-1:OFF_W]),
    .snp_valid_i (snp_valid_i),
    .snp_inv_i   (snp_inv_i),
    .snp_addr_i  (snp_addr_i),
    .retire_i    (fill_fire),
    .hit_o       (snp_hit),
    .deferred_o  (deferred)
  );

  mt_fill_path #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fill_fire),
    .line_i      (fill_data_i),
    .widx_i      (ent_addr_q[OFF_W-1:WOFF_W]),
    .write_i     (ent_write_q),
    .inval_i     (inval_now),
    .addr_i      (ent_addr_q),
    .rsp_valid_o (cpu_rsp_valid_o),
    .rsp_inval_o (cpu_rsp_inval_o),
    .rsp_addr_o  (cpu_rsp_addr_o),
    .rsp_data_o  (cpu_rsp_data_o)
  );
endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              bus_req_valid_o,
  input logic [ADDR_W-1:0] bus_req_addr_o,
  input logic              snp_valid_i,
  input logic              fill_valid_i,
  input logic              cpu_rsp_valid_o,
  input logic [1:0]        line_state_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R2
  req_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o |-> $past(miss_valid_i && miss_ready_o));

  // R2
  req_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_o |-> (bus_req_addr_o[OFF_W-1:0] == '0));

  // R4
  busy_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_ready_o |=> !bus_req_valid_o);

  // R5
  snoop_hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !miss_ready_o && !fill_valid_i) |=> $stable(line_state_o));

  // R9
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !miss_ready_o) |=> !cpu_rsp_valid_o ##1 cpu_rsp_valid_o);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_valid_o |=> !cpu_rsp_valid_o);
endmodule

bind miss_tracker miss_tracker_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .bus_req_valid_o (bus_req_valid_o),
  .bus_req_addr_o  (bus_req_addr_o),
  .snp_valid_i     (snp_valid_i),
  .fill_valid_i    (fill_valid_i),
  .cpu_rsp_valid_o (cpu_rsp_valid_o),
  .line_state_o    (line_state_o)
);

// File: tb/sim_miss_tracker.sv
module sim_miss_tracker;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         miss_valid_i = 1'b0, miss_write_i = 1'b0;
  logic [31:0]  miss_addr_i = '0;
  logic         snp_valid_i = 1'b0, snp_inv_i = 1'b0;
  logic [31:0]  snp_addr_i = '0;
  logic         fill_valid_i = 1'b0;
  logic [511:0] fill_data_i = '0;
  logic         miss_ready_o, bus_req_valid_o, cpu_rsp_valid_o, cpu_rsp_inval_o;
  logic [1:0]   bus_req_cmd_o, line_state_o;
  logic [31:0]  bus_req_addr_o, cpu_rsp_addr_o;
  logic [6:0]   bus_req_size_o;
  logic [63:0]  cpu_rsp_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic        inval;
    logic [31:0] addr;
    logic [63:0] data;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  miss_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_ready_o(miss_ready_o),
    .miss_write_i(miss_write_i), .miss_addr_i(miss_addr_i),
    .bus_req_valid_o(bus_req_valid_o), .bus_req_cmd_o(bus_req_cmd_o),
    .bus_req_addr_o(bus_req_addr_o), .bus_req_size_o(bus_req_size_o),
    .snp_valid_i(snp_valid_i), .snp_inv_i(snp_inv_i), .snp_addr_i(snp_addr_i),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .cpu_rsp_valid_o(cpu_rsp_valid_o), .cpu_rsp_inval_o(cpu_rsp_inval_o),
    .cpu_rsp_addr_o(cpu_rsp_addr_o), .cpu_rsp_data_o(cpu_rsp_data_o),
    .line_state_o(line_state_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_line(input logic [31:0] seed);
    logic [511:0] r;
    for (int k = 0; k < 8; k++) r[k*64 +: 64] = {seed, 32'(k) * 32'h0101_0101};
    return r;
  endfunction

  function automatic logic [63:0] word_of(input logic [31:0] seed, input logic [31:0] a);
    return {seed, 32'(a[5:3]) * 32'h0101_0101};
  endfunction

  // monitor: compares responses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (cpu_rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.due, "R9", "response cycle", 64'(cyc), 64'(e.due));
          chk(cpu_rsp_inval_o == e.inval, e.rq, "response inval tag", 64'(cpu_rsp_inval_o), 64'(e.inval));
          chk(cpu_rsp_addr_o == e.addr, e.rq, "response addr", 64'(cpu_rsp_addr_o), 64'(e.addr));
          chk(cpu_rsp_data_o == e.data, e.rq, "response data", cpu_rsp_data_o, e.data);
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0].due) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(0, "R9", "missing response", 64'(cyc), 64'(e.due));
      end
    end
  end

  // mode: 0 none, 1 same-line invalidate before fill, 2 other-line invalidate,
  //       3 same-line non-invalidating, 4 same-line invalidate with the fill
  task automatic do_txn(input bit wr, input logic [31:0] a, input int mode,
                        input logic [31:0] seed, input string rq);
    logic [1:0] st_pend, st_end;
    bit         inv;
    string      rq_req;
    exp_t       e;
    inv     = (mode == 1) || (mode == 4);
    st_pend = wr ? 2'd1 : 2'd0;
    st_end  = inv ? 2'd0 : (wr ? 2'd2 : 2'd1);
    rq_req  = wr ? "R3" : "R2";
    miss_valid_i = 1'b1; miss_write_i = wr; miss_addr_i = a;
    @(posedge clk); @(negedge clk);
    miss_valid_i = 1'b0;
    chk(bus_req_valid_o == 1'b1, rq_req, "bus req valid", 64'(bus_req_valid_o), 1);
    chk(bus_req_cmd_o == (wr ? 2'd2 : 2'd1), rq_req, "bus cmd", 64'(bus_req_cmd_o), wr ? 2 : 1);
    chk(bus_req_addr_o == (a & ~32'h3f), rq_req, "bus addr", 64'(bus_req_addr_o), 64'(a & ~32'h3f));
    chk(bus_req_size_o == (wr ? 7'd0 : 7'd64), rq_req, "bus size", 64'(bus_req_size_o), wr ? 0 : 64);
    chk(miss_ready_o == 1'b0, "R4", "ready while busy", 64'(miss_ready_o), 0);
    chk(line_state_o == st_pend, "R3", "pending line state", 64'(line_state_o), 64'(st_pend));
    if (mode >= 1 && mode <= 3) begin
      snp_valid_i = 1'b1;
      snp_inv_i   = (mode != 3);
      snp_addr_i  = (mode == 2) ? a + 32'h1000 : a ^ 32'h18;
      @(posedge clk); @(negedge clk);
      snp_valid_i = 1'b0;
      chk(line_state_o == st_pend, "R5", "state after snoop", 64'(line_state_o), 64'(st_pend));
      chk(bus_req_valid_o == 1'b0, "R4", "no repeat request", 64'(bus_req_valid_o), 0);
    end
    fill_valid_i = 1'b1;
    fill_data_i  = mk_line(seed);
    if (mode == 4) begin
      snp_valid_i = 1'b1; snp_inv_i = 1'b1; snp_addr_i = a ^ 32'h30;
    end
    e.due = cyc + 2; e.inval = inv; e.addr = a & ~32'h7;
    e.data = wr ? 64'd0 : word_of(seed, a); e.rq = rq;
    exp_q.push_back(e);
    @(posedge clk); @(negedge clk);
    fill_valid_i = 1'b0; snp_valid_i = 1'b0;
    chk(line_state_o == st_end, rq, "line state after fill", 64'(line_state_o), 64'(st_end));
    chk(cpu_rsp_valid_o == 1'b0, "R9", "no response on fill edge", 64'(cpu_rsp_valid_o), 0);
    chk(miss_ready_o == 1'b1, "R11", "entry retired", 64'(miss_ready_o), 1);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(miss_ready_o == 1'b1, "R1", "reset ready", 64'(miss_ready_o), 1);
    chk(bus_req_valid_o == 1'b0, "R1", "reset bus req", 64'(bus_req_valid_o), 0);
    chk(cpu_rsp_valid_o == 1'b0, "R1", "reset rsp", 64'(cpu_rsp_valid_o), 0);
    chk(line_state_o == 2'd0, "R1", "reset line state", 64'(line_state_o), 0);

    do_txn(0, 32'h0000_2068, 0, 32'hA001_0001, "R6");
    do_txn(0, 32'h0000_2068, 1, 32'hA002_0002, "R7");
    do_txn(0, 32'h0000_2068, 0, 32'hA003_0003, "R11");
    do_txn(0, 32'h0000_2068, 2, 32'hA004_0004, "R10");
    do_txn(0, 32'h0000_2070, 3, 32'hA005_0005, "R10");
    do_txn(1, 32'h0000_4010, 0, 32'hA006_0006, "R8");

    // R10: snoop while idle, R12: fill while idle; state stays Modified
    snp_valid_i = 1'b1; snp_inv_i = 1'b1; snp_addr_i = 32'h0000_4010;
    @(posedge clk); @(negedge clk);
    snp_valid_i = 1'b0;
    chk(line_state_o == 2'd2, "R10", "idle snoop ignored", 64'(line_state_o), 2);
    fill_valid_i = 1'b1; fill_data_i = mk_line(32'hBAD0_0000);
    @(posedge clk); @(negedge clk);
    fill_valid_i = 1'b0;
    chk(line_state_o == 2'd2, "R12", "idle fill state", 64'(line_state_o), 2);
    chk(miss_ready_o == 1'b1, "R12", "idle fill ready", 64'(miss_ready_o), 1);
    @(posedge clk); @(negedge clk);
    chk(cpu_rsp_valid_o == 1'b0, "R12", "idle fill no response", 64'(cpu_rsp_valid_o), 0);

    do_txn(1, 32'h0000_4010, 1, 32'hA007_0007, "R8");
    do_txn(0, 32'h0000_7FF8, 4, 32'hA008_0008, "R7");

    // R4: second miss stalls until the first retires
    miss_valid_i = 1'b1; miss_write_i = 1'b0; miss_addr_i = 32'h0000_5008;
    @(posedge clk); @(negedge clk);
    chk(bus_req_valid_o == 1'b1, "R2", "first request", 64'(bus_req_valid_o), 1);
    miss_addr_i = 32'h0000_6030;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(bus_req_valid_o == 1'b0, "R4", "stalled no request", 64'(bus_req_valid_o), 0);
      chk(miss_ready_o == 1'b0, "R4", "stalled ready low", 64'(miss_ready_o), 0);
    end
    begin
      exp_t e;
      fill_valid_i = 1'b1; fill_data_i = mk_line(32'hC001_0001);
      e.due = cyc + 2; e.inval = 1'b0; e.addr = 32'h0000_5008;
      e.data = word_of(32'hC001_0001, 32'h0000_5008); e.rq = "R6";
      exp_q.push_back(e);
    end
    @(posedge clk); @(negedge clk);
    fill_valid_i = 1'b0;
    chk(bus_req_valid_o == 1'b0, "R4", "not accepted on fill edge", 64'(bus_req_valid_o), 0);
    @(posedge clk); @(negedge clk);
    miss_valid_i = 1'b0;
    chk(bus_req_valid_o == 1'b1, "R4", "stalled miss accepted", 64'(bus_req_valid_o), 1);
    chk(bus_req_addr_o == 32'h0000_6000, "R4", "stalled miss addr", 64'(bus_req_addr_o), 64'h6000);
    begin
      exp_t e;
      fill_valid_i = 1'b1; fill_data_i = mk_line(32'hC002_0002);
      e.due = cyc + 2; e.inval = 1'b0; e.addr = 32'h0000_6030;
      e.data = word_of(32'hC002_0002, 32'h0000_6030); e.rq = "R6";
      exp_q.push_back(e);
    end
    @(posedge clk); @(negedge clk);
    fill_valid_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all responses seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule